// File: doc/BRIEF.md
# Register-Programmed Backlight Dimming Generator

This block drives a display backlight from a small byte-wide register file. A host writes a pre-divider, a power-of-two exponent and a brightness code through a single-cycle write port, and reads any register back combinationally. The block turns these settings into a pulse-width-modulated dimming signal and a separate lamp-enable output.

One PWM period lasts `DIV × 2^EXP` clock cycles. A prescaler counts `DIV` cycles per step, and a step counter walks through `2^EXP` steps. The output is high while the step counter is below the top `EXP` bits of the brightness code. Zero brightness keeps the output low for the whole period, and full-scale brightness keeps it high for the whole period. Divider, exponent and brightness writes land in shadow copies first. These copies become active only on the last cycle of a period, so a period already in progress always finishes with the settings it started with.

A source field decides whether the register brightness drives the output. Only the register source does; every other source leaves `pwm_o` low. A frequency-select bit chooses between the programmed divider and exponent and a built-in default pair. The capability bytes are set by parameters and cannot be written.

Top module: `backlight_pwm`

## Requirements
- R1: After reset, `pwm_o` and `bl_en_o` are 0. The divider register (0x05) reads `DEF_DIV`, the exponent register (0x04) reads `DEF_EXP`, and the brightness high byte (0x02) reads 0.
- R2: In register source with the lamp enabled and the frequency bit set, the period is `DIV × 2^EXP` cycles. The output is high for `DIV × floor(level × 2^EXP / 2^16)` cycles of each period. `level` is {0x02, 0x03} in wide mode and {0x02, 8'h00} in narrow mode.
- R3: A write to the exponent register keeps bits 4:0 and clamps them into [`EXP_MIN`, `EXP_MAX`]. A divider write of 0 is stored as 1. Reads return the stored value.
- R4: A brightness of 0 gives a constant low output. A full-scale brightness (0xFFFF wide, high byte 0xFF narrow) gives a constant high output.
- R5: `bl_en_o` follows bit 0 of the control register (0x00). While that bit is 0, `pwm_o` is held low.
- R6: Bits 1:0 of the mode register (0x01) select the source: 0 pin, 1 preset, 2 register, 3 product-specific. With any value other than 2, `pwm_o` is held low whatever the brightness.
- R7: While bit 7 of the mode register is 0, the period uses `DEF_DIV` and `DEF_EXP` and ignores the programmed divider and exponent.
- R8: Divider, exponent and brightness writes take effect only after the current period ends. The rest of the period keeps the old settings.
- R9: With `WIDE_LVL`=0, only the high brightness byte is used. Register 0x03 reads 0 and writes to it have no effect on the output.
- R10: The read-only capability bytes are 0x08 (`EXP_MIN`), 0x09 (`EXP_MAX`) and 0x0A (bit 0 = `WIDE_LVL`). Writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| bl_en_o | output | 1 | Lamp enable |
| pwm_o | output | 1 | Dimming output |

## Verification
The bench builds two copies with `EXP_MIN`=1, `EXP_MAX`=4, `DEF_DIV`=3 and `DEF_EXP`=2. One copy has a 16-bit brightness and the other an 8-bit brightness, and both share one write bus. Periods stay within a few dozen cycles, so a single run can measure whole periods and push the exponent past both capability limits. The paired copies show the narrow low-byte behaviour and the different full-scale points side by side. A rising-edge sync lets the bench write in the middle of a period and watch that the old duty holds until the boundary.

// File: rtl/blpwm_pkg.sv
package blpwm_pkg;

  // register addresses
  localparam logic [7:0] A_CTRL      = 8'h00;
  localparam logic [7:0] A_MODE      = 8'h01;
  localparam logic [7:0] A_LVL_HI    = 8'h02;
  localparam logic [7:0] A_LVL_LO    = 8'h03;
  localparam logic [7:0] A_EXP       = 8'h04;
  localparam logic [7:0] A_DIV       = 8'h05;
  localparam logic [7:0] A_CAP_MIN   = 8'h08;
  localparam logic [7:0] A_CAP_MAX   = 8'h09;
  localparam logic [7:0] A_CAP_FLAGS = 8'h0A;

  typedef enum logic [1:0] {
    SRC_PIN    = 2'd0,
    SRC_PRESET = 2'd1,
    SRC_REG    = 2'd2,
    SRC_VENDOR = 2'd3
  } src_e;

  typedef struct packed {
    logic [7:0]  div;
    logic [4:0]  exp;
    logic [15:0] lvl;
  } tone_t;

  // R3: exponent limited to capability window
  function automatic logic [4:0] clamp_exp(input logic [4:0] v,
                                           input logic [4:0] lo,
                                           input logic [4:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // R3: divider of zero promoted to one
  function automatic logic [7:0] fix_div(input logic [7:0] v);
    return (v == 8'h00) ? 8'h01 : v;
  endfunction

  // R2: top e bits of a left-aligned 16-bit level (e <= 16)
  function automatic logic [15:0] duty_code(input logic [15:0] lvl,
                                            input logic [4:0] e);
    logic [4:0] sh;
    sh = 5'd16 - e;
    return lvl >> sh;
  endfunction

  // R4: full-scale detection per brightness width
  function automatic logic is_full(input logic [15:0] lvl, input bit wide);
    return wide ? (lvl == 16'hFFFF) : (lvl[15:8] == 8'hFF);
  endfunction

  // last step index of a 2^e step period
  function automatic logic [15:0] step_top(input logic [4:0] e);
    logic [16:0] t;
    t = (17'd1 << e) - 17'd1;
    return t[15:0];
  endfunction

endpackage

// File: rtl/blpwm_regs.sv
module blpwm_regs
  import blpwm_pkg::*;
#(
  parameter bit WIDE_LVL = 1'b1,
  parameter int EXP_MIN  = 1,
  parameter int EXP_MAX  = 16,
  parameter int DEF_DIV  = 200,
  parameter int DEF_EXP  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       en_bit,
  output logic       freq_en,
  output src_e       src,
  output tone_t      shadow
);

  localparam logic [4:0] EXP_LO = 5'(EXP_MIN);
  localparam logic [4:0] EXP_HI = 5'(EXP_MAX);

  logic [7:0] lvl_hi_q;
  logic [7:0] lvl_lo_q;
  logic [7:0] div_q;
  logic [4:0] exp_q;

  // capability addresses have no write path (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_bit   <= 1'b0;
      freq_en  <= 1'b0;
      src      <= SRC_PIN;
      lvl_hi_q <= 8'h00;
      div_q    <= 8'(DEF_DIV);
      exp_q    <= 5'(DEF_EXP);
    end else if (we) begin
      case (addr)
        A_CTRL:   en_bit   <= wdata[0];
        A_MODE: begin
          src     <= src_e'(wdata[1:0]);
          freq_en <= wdata[7];
        end
        A_LVL_HI: lvl_hi_q <= wdata;
        A_EXP:    exp_q    <= clamp_exp(wdata[4:0], EXP_LO, EXP_HI);  // R3
        A_DIV:    div_q    <= fix_div(wdata);                         // R3
        default:  ;
      endcase
    end
  end

  // R9: low brightness byte exists only in the wide variant
  generate
    if (WIDE_LVL) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       lvl_lo_q <= 8'h00;
        else if (we && addr == A_LVL_LO)  lvl_lo_q <= wdata;
      end
    end else begin : g_narrow
      assign lvl_lo_q = 8'h00;
    end
  endgenerate

  always_comb begin
    case (addr)
      A_CTRL:      rdata = {7'd0, en_bit};
      A_MODE:      rdata = {freq_en, 5'd0, src};
      A_LVL_HI:    rdata = lvl_hi_q;
      A_LVL_LO:    rdata = lvl_lo_q;
      A_EXP:       rdata = {3'd0, exp_q};
      A_DIV:       rdata = div_q;
      A_CAP_MIN:   rdata = {3'd0, EXP_LO};
      A_CAP_MAX:   rdata = {3'd0, EXP_HI};
      A_CAP_FLAGS: rdata = {7'd0, WIDE_LVL};
      default:     rdata = 8'h00;
    endcase
  end

  assign shadow.div = div_q;
  assign shadow.exp = exp_q;
  assign shadow.lvl = {lvl_hi_q, lvl_lo_q};

endmodule

// File: rtl/blpwm_gen.sv
module blpwm_gen
  import blpwm_pkg::*;
#(
  parameter bit WIDE_LVL = 1'b1,
  parameter int EXP_MAX  = 16,
  parameter int DEF_DIV  = 200,
  parameter int DEF_EXP  = 8,
  parameter int CW       = EXP_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tone_t         shadow,
  input  logic          freq_en,
  input  logic          drive,
  output logic          pwm,
  output logic          period_end,
  output logic [7:0]    act_div,
  output logic [4:0]    act_exp,
  output logic [7:0]    pre_cnt,
  output logic [CW-1:0] per_cnt
);

  logic [7:0]    nxt_div;
  logic [4:0]    nxt_exp;
  logic [15:0]   act_duty;
  logic          act_full;
  logic          tick;
  logic [15:0]   top_w;
  logic [CW-1:0] cnt_top;

  // R7: default pair when programmed frequency is not selected
  always_comb begin
    nxt_div = freq_en ? shadow.div : 8'(DEF_DIV);
    nxt_exp = freq_en ? shadow.exp : 5'(DEF_EXP);
  end

  assign top_w      = step_top(act_exp);
  assign cnt_top    = CW'(top_w);
  assign tick       = (pre_cnt == act_div - 8'd1);
  assign period_end = tick && (per_cnt == cnt_top);

  // R2: prescaler and step counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= 8'd0;
      per_cnt <= '0;
    end else begin
      pre_cnt <= tick ? 8'd0 : pre_cnt + 8'd1;
      if (tick) per_cnt <= period_end ? '0 : per_cnt + CW'(1);
    end
  end

  // R8: shadow copied to active set only on the period's last cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div  <= 8'(DEF_DIV);
      act_exp  <= 5'(DEF_EXP);
      act_duty <= 16'd0;
      act_full <= 1'b0;
    end else if (period_end) begin
      act_div  <= nxt_div;
      act_exp  <= nxt_exp;
      act_duty <= duty_code(shadow.lvl, nxt_exp);
      act_full <= is_full(shadow.lvl, WIDE_LVL);
    end
  end

  // R4, R5, R6: gated compare
  assign pwm = drive && (act_full || (16'(per_cnt) < act_duty));

endmodule

// File: rtl/backlight_pwm.sv
module backlight_pwm
  import blpwm_pkg::*;
#(
  parameter bit WIDE_LVL = 1'b1,
  parameter int EXP_MIN  = 1,
  parameter int EXP_MAX  = 16,
  parameter int DEF_DIV  = 200,
  parameter int DEF_EXP  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       bl_en_o,
  output logic       pwm_o
);

  localparam int CW = EXP_MAX;

  logic          en_bit;
  logic          freq_en;
  src_e          src;
  tone_t         shadow;
  logic          drive;
  logic          period_end;
  logic [7:0]    act_div;
  logic [4:0]    act_exp;
  logic [7:0]    pre_cnt;
  logic [CW-1:0] per_cnt;

  blpwm_regs #(
    .WIDE_LVL(WIDE_LVL), .EXP_MIN(EXP_MIN), .EXP_MAX(EXP_MAX),
    .DEF_DIV(DEF_DIV), .DEF_EXP(DEF_EXP)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .en_bit(en_bit), .freq_en(freq_en), .src(src),
    .shadow(shadow)
  );

  // R5, R6: only register source with lamp on may drive
  assign drive   = en_bit && (src == SRC_REG);
  assign bl_en_o = en_bit;

  blpwm_gen #(
    .WIDE_LVL(WIDE_LVL), .EXP_MAX(EXP_MAX), .DEF_DIV(DEF_DIV),
    .DEF_EXP(DEF_EXP), .CW(CW)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .shadow(shadow), .freq_en(freq_en),
    .drive(drive), .pwm(pwm_o), .period_end(period_end),
    .act_div(act_div), .act_exp(act_exp), .pre_cnt(pre_cnt),
    .per_cnt(per_cnt)
  );

endmodule

// File: rtl/backlight_pwm_chk.sv
module backlight_pwm_chk #(
  parameter int EXP_MIN = 1,
  parameter int EXP_MAX = 16,
  parameter int CW      = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwm_o,
  input logic          bl_en_o,
  input logic          period_end,
  input logic [7:0]    act_div,
  input logic [4:0]    act_exp,
  input logic [7:0]    pre_cnt,
  input logic [CW-1:0] per_cnt
);

  a_r5_lamp_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !bl_en_o |-> !pwm_o);

  a_r3_exp_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (act_exp >= 5'(EXP_MIN)) && (act_exp <= 5'(EXP_MAX)));

  a_r3_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    act_div != 8'd0);

  a_r8_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> ($stable(act_div) && $stable(act_exp)));

  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (per_cnt == '0 && pre_cnt == 8'd0));

  a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt < act_div);

endmodule

bind backlight_pwm backlight_pwm_chk #(
  .EXP_MIN(EXP_MIN), .EXP_MAX(EXP_MAX), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_o(pwm_o), .bl_en_o(bl_en_o),
  .period_end(period_end), .act_div(act_div), .act_exp(act_exp),
  .pre_cnt(pre_cnt), .per_cnt(per_cnt)
);

// File: tb/backlight_pwm_test.sv
`timescale 1ns/1ps
module backlight_pwm_test;

  localparam int P_MIN = 1, P_MAX = 4, P_DDIV = 3, P_DEXP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata, rdata_n;
  logic       bl_en_o, en_n, pwm_o, pwm_n;

  int n_tot = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  backlight_pwm #(.WIDE_LVL(1'b1), .EXP_MIN(P_MIN), .EXP_MAX(P_MAX),
                  .DEF_DIV(P_DDIV), .DEF_EXP(P_DEXP)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bl_en_o(bl_en_o),
    .pwm_o(pwm_o));

  backlight_pwm #(.WIDE_LVL(1'b0), .EXP_MIN(P_MIN), .EXP_MAX(P_MAX),
                  .DEF_DIV(P_DDIV), .DEF_EXP(P_DEXP)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_n), .bl_en_o(en_n),
    .pwm_o(pwm_n));

  // {freq_en, div, exp, level}
  localparam logic [32:0] VEC [8] = '{
    {1'b1, 8'd2, 8'd3, 16'h8000},
    {1'b1, 8'd1, 8'd4, 16'h3000},
    {1'b1, 8'd5, 8'd2, 16'hC000},
    {1'b1, 8'd3, 8'd7, 16'h1000},
    {1'b1, 8'd4, 8'd0, 16'h7FFF},
    {1'b0, 8'd6, 8'd4, 16'h4000},
    {1'b1, 8'd0, 8'd2, 16'hFFFF},
    {1'b1, 8'd2, 8'd4, 16'h0000}
  };

  task automatic check(input string req, input int act, input int expv);
    n_tot++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v, output int vn);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
    vn = int'(rdata_n);
  endtask

  task automatic measure(input int n, output int hw, output int hn);
    hw = 0; hn = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_o) hw++;
      if (pwm_n) hn++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tot++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    int v, vn, hw, hn;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 pwm", int'(pwm_o), 0);
    check("R1 lamp", int'(bl_en_o), 0);
    rd(8'h04, v, vn); check("R1 exp", v, P_DEXP);
    rd(8'h05, v, vn); check("R1 div", v, P_DDIV);
    rd(8'h02, v, vn); check("R1 level", v, 0);

    // R10 capability bytes, read-only
    rd(8'h08, v, vn); check("R10 cap min", v, P_MIN);
    rd(8'h09, v, vn); check("R10 cap max", v, P_MAX);
    rd(8'h0A, v, vn); check("R10 flags wide", v, 1); check("R10 flags narrow", vn, 0);
    wr(8'h08, 8'h00); wr(8'h09, 8'h1F); wr(8'h0A, 8'h00);
    rd(8'h08, v, vn); check("R10 min after write", v, P_MIN);
    rd(8'h09, v, vn); check("R10 max after write", v, P_MAX);
    rd(8'h0A, v, vn); check("R10 flags after write", v, 1);

    // R3 clamping on write
    wr(8'h04, 8'd9);  rd(8'h04, v, vn); check("R3 exp above max", v, P_MAX);
    wr(8'h04, 8'd0);  rd(8'h04, v, vn); check("R3 exp below min", v, P_MIN);
    wr(8'h04, 8'h23); rd(8'h04, v, vn); check("R3 exp field bits", v, 3);
    wr(8'h05, 8'd0);  rd(8'h05, v, vn); check("R3 div zero", v, 1);

    // R5 lamp enable, R6 register source
    wr(8'h00, 8'h01); wr(8'h01, 8'h82);
    #1 check("R5 lamp on", int'(bl_en_o), 1);

    // table walk: R2, R3, R4, R7
    for (int k = 0; k < 8; k++) begin
      bit fe; int dv, ex, lv, ed, ee, per, duty, hexp; string tag;
      fe = VEC[k][32]; dv = int'(VEC[k][31:24]); ex = int'(VEC[k][23:16]);
      lv = int'(VEC[k][15:0]);
      wr(8'h01, {fe, 5'd0, 2'd2});
      wr(8'h05, 8'(dv)); wr(8'h04, 8'(ex));
      wr(8'h02, 8'(lv >> 8)); wr(8'h03, 8'(lv & 255));
      repeat (200) @(negedge clk);
      ed = fe ? ((dv == 0) ? 1 : dv) : P_DDIV;
      ee = fe ? ((ex < P_MIN) ? P_MIN : ((ex > P_MAX) ? P_MAX : ex)) : P_DEXP;
      per = ed * (1 << ee);
      duty = (lv * (1 << ee)) / 65536;
      hexp = (lv == 65535) ? per : ed * duty;
      if (lv == 0 || lv == 65535) tag = "R4 level extreme";
      else if (!fe) tag = "R7 default period";
      else if (ex < P_MIN || ex > P_MAX) tag = "R3 clamped period";
      else tag = "R2 duty";
      measure(3 * per, hw, hn);
      check(tag, hw, 3 * hexp);
    end

    // R9 narrow brightness: low byte unused
    wr(8'h01, 8'h82); wr(8'h05, 8'd2); wr(8'h04, 8'd3);
    wr(8'h02, 8'hFF); wr(8'h03, 8'h00);
    repeat (200) @(negedge clk);
    measure(48, hw, hn);
    check("R9 wide not full", hw, 42);
    check("R9 narrow full-scale", hn, 48);
    wr(8'h03, 8'h55);
    rd(8'h03, v, vn);
    check("R9 narrow low reads zero", vn, 0);
    check("R9 wide low readback", v, 8'h55);
    wr(8'h02, 8'h40); wr(8'h03, 8'hFF);
    repeat (200) @(negedge clk);
    measure(48, hw, hn);
    check("R9 narrow ignores low", hn, 12);

    // R5 lamp off forces low
    wr(8'h02, 8'h80); wr(8'h03, 8'h00); wr(8'h00, 8'h00);
    #1 check("R5 lamp off", int'(bl_en_o), 0);
    repeat (100) @(negedge clk);
    measure(48, hw, hn); check("R5 output with lamp off", hw, 0);
    wr(8'h00, 8'h01);

    // R6 non-register sources
    wr(8'h01, 8'h80); repeat (100) @(negedge clk);
    measure(48, hw, hn); check("R6 pin source", hw, 0);
    wr(8'h01, 8'h83); repeat (100) @(negedge clk);
    measure(48, hw, hn); check("R6 product source", hw, 0);
    wr(8'h01, 8'h82); repeat (100) @(negedge clk);
    measure(48, hw, hn); check("R6 register source", hw, 24);

    // R8 mid-period write holds until boundary (F=2, exp=3, duty 4)
    begin
      logic prev; bit found;
      prev = 1'b1; found = 1'b0;
      for (int i = 0; i < 200 && !found; i++) begin
        @(negedge clk);
        if (pwm_o && !prev) found = 1'b1;
        else prev = pwm_o;
      end
      check("R8 period sync found", int'(found), 1);
      reg_we = 1'b1; reg_addr = 8'h02; reg_wdata = 8'h00;
      @(negedge clk);
      reg_we = 1'b0;
      check("R8 old duty kept", int'(pwm_o), 1);
      repeat (4) @(negedge clk);
      check("R8 old duty still kept", int'(pwm_o), 1);
      repeat (40) @(negedge clk);
      measure(48, hw, hn); check("R8 new level after boundary", hw, 0);
    end

    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

endmodule